// File: doc/BRIEF.md
# Pulse-Distance Infrared Frame Receiver

This block decodes the pulse-distance infrared remote-control format. The raw pin goes through a synchronizer chain of `SYNC_STAGES` flip-flops. A polarity select then maps the pin level to "mark" or "space". A counter measures each mark and each space in ticks supplied from outside. One tick is one eighth of the 562.5 µs base unit.

A control state machine compares each measured interval against a window around its nominal length. From those comparisons it recognises two kinds of input:

- **Full frame.** A lead mark, a gap, 32 data bits and a closing mark.
- **Repeat code.** A lead mark, a short gap and a closing mark. Detection of repeat codes can be switched on or off.

Each accepted result is offered to a downstream FIFO as a 17-bit word with a one-cycle write strobe. Interval lengths in ticks, with `U = UNIT_TICKS` (8 by default):

| Interval | Nominal length |
|---|---|
| Lead mark | 16·U |
| Frame gap | 8·U |
| Repeat gap | 4·U |
| Bit mark | U |
| Space for a 0 | U |
| Space for a 1 | 3·U |
| Closing mark | U |

The idle space before a lead mark is not measured.

Top module: `ir_pd_receiver`

## Requirements
- R1: With `polHigh`=0 a low pin level is a mark and a high level is a space. With `polHigh`=1 a high pin level is a mark. A frame sent with the levels that match the selected polarity decodes identically in both settings.
- R2: A full frame carries 32 bits in four bytes, each byte least significant bit first, in this order:
  - address
  - inverted address
  - command
  - inverted command
  
  When the closing mark ends, the block raises `fifoWrEn` for one cycle with `fifoWrData` = {1'b0, address[7:0], command[7:0]}. Bit 16 is the repeat flag, bits [15:8] are the address and bits [7:0] are the command.
- R3: Every interval is accepted when its tick count lies within nominal ±25 % (integer quarter of the nominal). Frames stretched to 120 % or shrunk to 80 % of nominal still decode.
- R4: A completed interval whose length is outside its window returns the decoder to idle with no write. A later valid frame then decodes normally.
- R5: A frame whose address byte differs from the inverse of its inverted-address byte, or whose command byte differs from the inverse of its inverted-command byte, is dropped with no write. It does not change the payload stored for repeat codes.
- R6: With `repeatEn`=1, a lead mark, a 4-unit gap and a 1-unit closing mark produce one write of {1'b1, address, command} of the last valid frame. Before any valid frame this payload is zero.
- R7: With `repeatEn`=0 a repeat code produces no write.
- R8: When the current interval grows past its upper limit, the decoder returns to idle at once, without waiting for the next edge. This means a frame that starts right after a stalled, idle line is still decoded.
- R9: While `enable` is 0 the decoder is held idle and no write occurs. A frame that is interrupted by `enable` dropping is lost.
- R10: `fifoWrEn` is never high on two consecutive cycles, and `fifoWrData` holds its value between writes.
- R11: After reset `fifoWrEn` is 0 and `fifoWrData` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| irPin | input | 1 | Raw infrared receiver pin |
| tick | input | 1 | One-cycle pulse every 1/8 of the base unit |
| enable | input | 1 | Decoder enable; 0 holds it idle |
| polHigh | input | 1 | 1: a high level is a mark; 0: a low level is a mark |
| repeatEn | input | 1 | Enables recognition of repeat codes |
| fifoWrData | output | 17 | {repeat flag, address, command} |
| fifoWrEn | output | 1 | One-cycle FIFO write strobe |

## Verification
The bound checker watches several properties on every cycle:

- The write strobe is never longer than one cycle, and the word holds between writes.
- Nothing is written the cycle after `enable` is low.
- A word carrying the repeat flag only appears when repeat detection was enabled.
- Each frame or repeat action of the control unit becomes a word with the matching flag on the next cycle.
- At most one control action fires per cycle.

The checker cannot judge whether a decoded payload is right. That needs the directed scenarios, which cover:

- the bit order and byte order;
- the ±25 % windows at both ends;
- aborts on short, long and stalled intervals;
- the inverse check;
- the replay of the stored payload by repeat codes;
- the two polarity settings.

// File: rtl/ir_pd_pkg.sv
package ir_pd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_GAP,
    ST_BMARK,
    ST_BSPACE,
    ST_ENDMARK,
    ST_REPMARK
  } rxState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic clrCount;
    logic shiftBit;
    logic bitVal;
    logic writeFrame;
    logic writeRepeat;
  } rxStrobe_t;

  // Upper acceptance limit: nominal plus a quarter
  function automatic int winHigh(input int nominal);
    return nominal + nominal / 4;
  endfunction

  // Lower acceptance limit: nominal minus a quarter
  function automatic int winLow(input int nominal);
    return nominal - nominal / 4;
  endfunction

  function automatic logic inWindow(input int measured, input int nominal);
    return (measured >= winLow(nominal)) && (measured <= winHigh(nominal));
  endfunction

endpackage

// File: rtl/ir_pd_datapath.sv
module ir_pd_datapath
  import ir_pd_pkg::*;
#(
  parameter int SYNC_STAGES = 3,
  parameter int CNT_W       = 8,
  parameter int BYTE_W      = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  irPin,
  input  logic                  polHigh,
  input  logic                  tick,
  input  rxStrobe_t             strobes,
  output logic                  markRise,
  output logic                  markFall,
  output logic [CNT_W-1:0]      tickCount,
  output logic                  frameOk,
  output logic [2*BYTE_W:0]     wrData,
  output logic                  wrEn
);
  localparam int FRAME_BITS = 4 * BYTE_W;
  localparam int PAY_W      = 2 * BYTE_W;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   markNow;
  logic                   markPrev;
  logic [FRAME_BITS-1:0]  shiftReg;
  logic [PAY_W-1:0]       lastPayload;
  logic [BYTE_W-1:0]      addrByte, addrInv, cmdByte, cmdInv;

  // Input synchronizer (SYNC_STAGES must be 2 or more)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncChain <= '0;
    else       syncChain <= {syncChain[SYNC_STAGES-2:0], irPin};
  end

  assign markNow  = polHigh ? syncChain[SYNC_STAGES-1] : ~syncChain[SYNC_STAGES-1];
  assign markRise = markNow & ~markPrev;
  assign markFall = ~markNow & markPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) markPrev <= 1'b0;
    else       markPrev <= markNow;
  end

  // Interval counter; the tick of the clearing cycle belongs to the new interval
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                             tickCount <= '0;
    else if (strobes.clrCount)             tickCount <= tick ? CNT_W'(1) : '0;
    else if (tick && tickCount != CNT_MAX) tickCount <= tickCount + CNT_W'(1);
  end

  // Payload shift register, least significant bit arrives first
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 shiftReg <= '0;
    else if (strobes.shiftBit) shiftReg <= {strobes.bitVal, shiftReg[FRAME_BITS-1:1]};
  end

  assign addrByte = shiftReg[BYTE_W-1:0];
  assign addrInv  = shiftReg[2*BYTE_W-1:BYTE_W];
  assign cmdByte  = shiftReg[3*BYTE_W-1:2*BYTE_W];
  assign cmdInv   = shiftReg[4*BYTE_W-1:3*BYTE_W];
  assign frameOk  = (addrByte == ~addrInv) && (cmdByte == ~cmdInv);

  // Output word and stored payload for repeat codes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastPayload <= '0;
      wrData      <= '0;
      wrEn        <= 1'b0;
    end else begin
      wrEn <= strobes.writeFrame | strobes.writeRepeat;
      if (strobes.writeFrame) begin
        lastPayload <= {addrByte, cmdByte};
        wrData      <= {1'b0, addrByte, cmdByte};
      end else if (strobes.writeRepeat) begin
        wrData      <= {1'b1, lastPayload};
      end
    end
  end

endmodule

// File: rtl/ir_pd_control.sv
module ir_pd_control
  import ir_pd_pkg::*;
#(
  parameter int UNIT_TICKS = 8,
  parameter int CNT_W      = 8,
  parameter int FRAME_BITS = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             repeatEn,
  input  logic             markRise,
  input  logic             markFall,
  input  logic [CNT_W-1:0] tickCount,
  input  logic             frameOk,
  output rxStrobe_t        strobes
);
  localparam int NOM_LEAD = 16 * UNIT_TICKS;
  localparam int NOM_GAP  = 8 * UNIT_TICKS;
  localparam int NOM_REP  = 4 * UNIT_TICKS;
  localparam int NOM_UNIT = UNIT_TICKS;
  localparam int NOM_ONE  = 3 * UNIT_TICKS;
  localparam int IDX_W    = $clog2(FRAME_BITS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);

  rxState_t         state, nextState;
  logic [IDX_W-1:0] bitIdx, nextIdx;
  int               cnt;

  assign cnt = int'(tickCount);

  always_comb begin
    nextState = state;
    nextIdx   = bitIdx;
    strobes   = '0;
    if (!enable) begin
      nextState        = ST_IDLE;
      strobes.clrCount = 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: begin
          strobes.clrCount = 1'b1;
          if (markRise) nextState = ST_LEAD;
        end
        ST_LEAD: begin
          if (markFall) begin
            strobes.clrCount = 1'b1;
            nextState = inWindow(cnt, NOM_LEAD) ? ST_GAP : ST_IDLE;
          end else if (cnt > winHigh(NOM_LEAD)) nextState = ST_IDLE;
        end
        ST_GAP: begin
          if (markRise) begin
            strobes.clrCount = 1'b1;
            if (inWindow(cnt, NOM_GAP)) begin
              nextState = ST_BMARK;
              nextIdx   = '0;
            end else if (repeatEn && inWindow(cnt, NOM_REP)) nextState = ST_REPMARK;
            else nextState = ST_IDLE;
          end else if (cnt > winHigh(NOM_GAP)) nextState = ST_IDLE;
        end
        ST_BMARK: begin
          if (markFall) begin
            strobes.clrCount = 1'b1;
            nextState = inWindow(cnt, NOM_UNIT) ? ST_BSPACE : ST_IDLE;
          end else if (cnt > winHigh(NOM_UNIT)) nextState = ST_IDLE;
        end
        ST_BSPACE: begin
          if (markRise) begin
            strobes.clrCount = 1'b1;
            if (inWindow(cnt, NOM_UNIT) || inWindow(cnt, NOM_ONE)) begin
              strobes.shiftBit = 1'b1;
              strobes.bitVal   = inWindow(cnt, NOM_ONE);
              nextIdx          = bitIdx + IDX_W'(1);
              nextState        = (bitIdx == LAST_IDX) ? ST_ENDMARK : ST_BMARK;
            end else nextState = ST_IDLE;
          end else if (cnt > winHigh(NOM_ONE)) nextState = ST_IDLE;
        end
        ST_ENDMARK: begin
          if (markFall) begin
            strobes.clrCount   = 1'b1;
            strobes.writeFrame = inWindow(cnt, NOM_UNIT) && frameOk;
            nextState          = ST_IDLE;
          end else if (cnt > winHigh(NOM_UNIT)) nextState = ST_IDLE;
        end
        ST_REPMARK: begin
          if (markFall) begin
            strobes.clrCount    = 1'b1;
            strobes.writeRepeat = inWindow(cnt, NOM_UNIT);
            nextState           = ST_IDLE;
          end else if (cnt > winHigh(NOM_UNIT)) nextState = ST_IDLE;
        end
        default: nextState = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitIdx <= '0;
    end else begin
      state  <= nextState;
      bitIdx <= nextIdx;
    end
  end

endmodule

// File: rtl/ir_pd_receiver.sv
module ir_pd_receiver
  import ir_pd_pkg::*;
#(
  parameter int SYNC_STAGES = 3,
  parameter int UNIT_TICKS  = 8,
  parameter int BYTE_W      = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              irPin,
  input  logic              tick,
  input  logic              enable,
  input  logic              polHigh,
  input  logic              repeatEn,
  output logic [2*BYTE_W:0] fifoWrData,
  output logic              fifoWrEn
);
  // Counter must reach beyond the longest window limit so overrun is visible
  localparam int LONGEST = 20 * UNIT_TICKS;
  localparam int CNT_W   = $clog2(LONGEST + 2);

  rxStrobe_t        strobes;
  logic             markRise, markFall, frameOk;
  logic [CNT_W-1:0] tickCount;

  ir_pd_datapath #(
    .SYNC_STAGES(SYNC_STAGES),
    .CNT_W      (CNT_W),
    .BYTE_W     (BYTE_W)
  ) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .irPin    (irPin),
    .polHigh  (polHigh),
    .tick     (tick),
    .strobes  (strobes),
    .markRise (markRise),
    .markFall (markFall),
    .tickCount(tickCount),
    .frameOk  (frameOk),
    .wrData   (fifoWrData),
    .wrEn     (fifoWrEn)
  );

  ir_pd_control #(
    .UNIT_TICKS(UNIT_TICKS),
    .CNT_W     (CNT_W),
    .FRAME_BITS(4 * BYTE_W)
  ) i_control (
    .clk      (clk),
    .rstN     (rstN),
    .enable   (enable),
    .repeatEn (repeatEn),
    .markRise (markRise),
    .markFall (markFall),
    .tickCount(tickCount),
    .frameOk  (frameOk),
    .strobes  (strobes)
  );

endmodule

// File: rtl/ir_pd_receiver_sva.sv
module ir_pd_receiver_sva
  import ir_pd_pkg::*;
#(
  parameter int WORD_W = 17
) (
  input logic              clk,
  input logic              rstN,
  input logic              enable,
  input logic              repeatEn,
  input logic              fifoWrEn,
  input logic [WORD_W-1:0] fifoWrData,
  input rxStrobe_t         strobes
);

  assert_strobe_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    fifoWrEn |=> !fifoWrEn);

  assert_data_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !fifoWrEn |-> $stable(fifoWrData));

  assert_disabled_silent_R9: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !fifoWrEn);

  assert_repeat_gated_R7: assert property (@(posedge clk) disable iff (!rstN)
    (fifoWrEn && fifoWrData[WORD_W-1]) |-> $past(repeatEn));

  assert_frame_flag_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.writeFrame |=> (fifoWrEn && !fifoWrData[WORD_W-1]));

  assert_repeat_flag_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.writeRepeat |=> (fifoWrEn && fifoWrData[WORD_W-1]));

  assert_single_action_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.writeFrame, strobes.writeRepeat, strobes.shiftBit}));

endmodule

bind ir_pd_receiver ir_pd_receiver_sva #(.WORD_W(2 * BYTE_W + 1)) i_sva (
  .clk       (clk),
  .rstN      (rstN),
  .enable    (enable),
  .repeatEn  (repeatEn),
  .fifoWrEn  (fifoWrEn),
  .fifoWrData(fifoWrData),
  .strobes   (strobes)
);

// File: tb/test_ir_pd_receiver.sv
`timescale 1ns/1ps
module test_ir_pd_receiver;
  localparam int TICK_CLKS = 4;
  localparam int U         = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        irPin = 1'b1;
  logic        tick = 1'b0;
  logic        enable = 1'b1;
  logic        polHigh = 1'b0;
  logic        repeatEn = 1'b1;
  logic [16:0] fifoWrData;
  logic        fifoWrEn;

  int total = 0;
  int bad = 0;
  int capCount = 0;
  int widthErr = 0;
  logic [16:0] capData = '0;
  logic prevEn = 1'b0;
  int tickDiv = 0;

  ir_pd_receiver i_ir_pd_receiver (
    .clk(clk), .rstN(rstN), .irPin(irPin), .tick(tick), .enable(enable),
    .polHigh(polHigh), .repeatEn(repeatEn),
    .fifoWrData(fifoWrData), .fifoWrEn(fifoWrEn)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    tickDiv <= (tickDiv == TICK_CLKS - 1) ? 0 : tickDiv + 1;
    tick    <= (tickDiv == TICK_CLKS - 1);
  end

  // Output monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rstN && fifoWrEn) begin
      capCount++;
      capData = fifoWrData;
      if (prevEn) widthErr++;
    end
    prevEn = fifoWrEn;
  end

  task automatic checkEq(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic holdLevel(input logic lvl, input int ticks);
    irPin = lvl;
    repeat (ticks * TICK_CLKS) @(negedge clk);
  endtask

  task automatic mark(input int t);  holdLevel(polHigh, t);  endtask
  task automatic space(input int t); holdLevel(!polHigh, t); endtask

  function automatic int sc(input int n, input int pct);
    return n * pct / 100;
  endfunction

  // badBit >= 0 gives that bit a 14-tick space (between the two windows)
  task automatic sendFrame(input logic [7:0] a, input logic [7:0] ai,
                           input logic [7:0] c, input logic [7:0] ci,
                           input int pct, input int badBit);
    logic [31:0] bits;
    bits = {ci, c, ai, a};
    mark(sc(16 * U, pct));
    space(sc(8 * U, pct));
    for (int i = 0; i < 32; i++) begin
      mark(sc(U, pct));
      if (i == badBit) space(14);
      else space(bits[i] ? sc(3 * U, pct) : sc(U, pct));
    end
    mark(sc(U, pct));
    space(40);
  endtask

  task automatic sendGood(input logic [7:0] a, input logic [7:0] c);
    sendFrame(a, ~a, c, ~c, 100, -1);
  endtask

  task automatic sendRepeat();
    mark(16 * U); space(4 * U); mark(U); space(40);
  endtask

  task automatic t_reset();
    checkEq("R11 wrEn after reset", int'(fifoWrEn), 0);
    checkEq("R11 wrData after reset", int'(fifoWrData), 0);
  endtask

  task automatic t_repeatFirst();
    int n0 = capCount;
    sendRepeat();
    checkEq("R6 repeat before frame count", capCount - n0, 1);
    checkEq("R6 repeat before frame data", int'(capData), 'h10000);
  endtask

  task automatic t_basic();
    int n0 = capCount;
    sendGood(8'h5A, 8'h3C);
    checkEq("R2 frame count", capCount - n0, 1);
    checkEq("R2 frame data", int'(capData), 'h05A3C);
    n0 = capCount;
    sendGood(8'hFF, 8'h01);
    checkEq("R2 second frame count", capCount - n0, 1);
    checkEq("R2 second frame data", int'(capData), 'h0FF01);
  endtask

  task automatic t_tolerance();
    int n0 = capCount;
    sendFrame(8'h81, 8'h7E, 8'h7E, 8'h81, 120, -1);
    checkEq("R3 long frame count", capCount - n0, 1);
    checkEq("R3 long frame data", int'(capData), 'h0817E);
    n0 = capCount;
    sendFrame(8'h12, 8'hED, 8'hED, 8'h12, 80, -1);
    checkEq("R3 short frame count", capCount - n0, 1);
    checkEq("R3 short frame data", int'(capData), 'h012ED);
  endtask

  task automatic t_repeat();
    int n0 = capCount;
    sendRepeat();
    checkEq("R6 repeat count", capCount - n0, 1);
    checkEq("R6 repeat data", int'(capData), 'h112ED);
  endtask

  task automatic t_badInverse();
    int n0 = capCount;
    sendFrame(8'h44, 8'hBA, 8'h55, 8'hAA, 100, -1);
    checkEq("R5 address inverse wrong", capCount - n0, 0);
    sendFrame(8'h44, 8'hBB, 8'h55, 8'hAB, 100, -1);
    checkEq("R5 command inverse wrong", capCount - n0, 0);
    sendRepeat();
    checkEq("R5 stored payload unchanged", int'(capData), 'h112ED);
  endtask

  task automatic t_outOfRange();
    int n0 = capCount;
    mark(50); space(100);
    checkEq("R4 short lead mark", capCount - n0, 0);
    sendFrame(8'h21, 8'hDE, 8'h43, 8'hBC, 100, 9);
    checkEq("R4 bad bit space", capCount - n0, 0);
    sendGood(8'h21, 8'h43);
    checkEq("R4 recovery count", capCount - n0, 1);
    checkEq("R4 recovery data", int'(capData), 'h02143);
  endtask

  task automatic t_stall();
    int n0 = capCount;
    mark(16 * U);
    space(100);
    sendGood(8'h66, 8'h99);
    checkEq("R8 frame after stalled gap count", capCount - n0, 1);
    checkEq("R8 frame after stalled gap data", int'(capData), 'h06699);
  endtask

  task automatic t_repeatOff();
    int n0 = capCount;
    repeatEn = 1'b0;
    sendRepeat();
    checkEq("R7 repeat disabled", capCount - n0, 0);
    sendGood(8'h0F, 8'hF0);
    checkEq("R7 frame still decoded", int'(capData), 'h00FF0);
    repeatEn = 1'b1;
  endtask

  task automatic t_enable();
    int n0 = capCount;
    enable = 1'b0;
    sendGood(8'h33, 8'h44);
    checkEq("R9 disabled frame", capCount - n0, 0);
    enable = 1'b1;
    space(20);
    fork
      sendGood(8'h33, 8'h44);
      begin
        repeat (2000) @(negedge clk);
        enable = 1'b0;
        repeat (20) @(negedge clk);
        enable = 1'b1;
      end
    join
    checkEq("R9 interrupted frame", capCount - n0, 0);
    sendGood(8'h33, 8'h44);
    checkEq("R9 frame after re-enable", int'(capData), 'h03344);
  endtask

  task automatic t_polarity();
    int n0 = capCount;
    @(negedge clk);
    polHigh = 1'b1;
    irPin = 1'b0;
    space(60);
    sendGood(8'hC3, 8'h96);
    checkEq("R1 high-active count", capCount - n0, 1);
    checkEq("R1 high-active data", int'(capData), 'h0C396);
    @(negedge clk);
    polHigh = 1'b0;
    irPin = 1'b1;
    space(60);
  endtask

  task automatic t_hold();
    checkEq("R10 single-cycle strobe", widthErr, 0);
    checkEq("R10 data held", int'(fifoWrData), int'(capData));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (10) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    space(40);
    t_repeatFirst();
    t_basic();
    t_tolerance();
    t_repeat();
    t_badInverse();
    t_outOfRange();
    t_stall();
    t_repeatOff();
    t_enable();
    t_polarity();
    t_hold();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule